// File: doc/BRIEF.md
# NAND Page Sector Framer

This block turns the host byte stream for one flash page into the byte stream that is written to the device. The page is cut into a programmable number of sectors. Every sector except the final one carries the body length in data bytes, and the final sector carries the tail length. Each sector is laid out the same way. Its data bytes come first. An optional 8-byte checksum trailer follows, taken from a side input. Then come a programmable number of ECC bytes, taken from a second side input. Last come zero bytes that bring the sector's footprint up to a multiple of 8. The device column counter runs over main and spare areas as one space. When the hole is enabled, the counter jumps over a reserved bad-block-mark hole, and nothing is written there.

The controller is a five-state machine. IDLE goes to DATA on an accepted start. DATA goes to SUM, ECC or PAD in that order of preference, and each of those skips to the next one that applies. SUM goes to ECC or PAD. ECC goes to PAD. At the end of a sector, any of these phases returns to DATA for the next sector, or to IDLE after the last sector. A start is rejected, and the block stays in IDLE, when the sizes are illegal or when the page would not fit in the configured physical page size. All configuration inputs must be held stable while the block is busy.

All byte movement uses valid/ready. The output has no register stage: `out_valid` and `out_data` come from the active source, and the ready and request signals fed back to the sources follow `out_ready` in the same cycle.

Top module: `nsf_framer`

## Requirements
- R1: Sectors 0 to N-2 each take exactly `cfg_body_len` bytes from the input, and sector N-1 takes `cfg_tail_len` bytes. Those bytes appear on the output unchanged and in order.
- R2: With `cfg_sum_en` high, exactly 8 bytes from the checksum side input follow each sector's data, ahead of any ECC byte. With it low, the checksum input is never taken.
- R3: After the checksum bytes, each sector carries exactly `cfg_ecc_len` bytes (0 to 255) from the ECC side input, in order.
- R4: Bytes of value 0x00 follow until the sector's emitted count (data + checksum + ECC, hole excluded) is a multiple of 8. No padding is added when the count is already a multiple of 8.
- R5: When `cfg_sectors` is 0, when either length is 0, or when `cfg_even_req` is high and either length is odd, a start raises `cfg_err` in the next cycle and the page does not begin.
- R6: When `cfg_hole_en` is high and `cfg_hole_len` is nonzero, no byte is emitted at device columns `cfg_hole_at` up to `cfg_hole_at+cfg_hole_len-1`. The column jumps past the hole, and no input byte is taken for it.
- R7: `sect_stb` pulses with the first emitted byte of each sector, and `sect_col` then holds that byte's device column. Columns count from 0 at page start.
- R8: If the sum of the padded sector footprints plus the hole length (when enabled) exceeds `cfg_page_limit`, a start raises `ovf_err`, no byte is emitted and the block stays idle. A total equal to the limit is accepted.
- R9: `busy` rises in the cycle after an accepted start. `done` is high for one cycle, the cycle after the last byte of the last sector is accepted, and `busy` is low in that cycle.
- R10: With `out_ready` low, nothing advances. The byte sequence is identical under any backpressure pattern, with no byte lost or repeated.
- R11: `in_ready` is high only in the data phase of a sector.
- R12: A start applied while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a page when idle |
| cfg_sectors | input | SCW | Sector count |
| cfg_body_len | input | CW | Data bytes in every sector but the last |
| cfg_tail_len | input | CW | Data bytes in the last sector |
| cfg_sum_en | input | 1 | Append 8 checksum bytes per sector |
| cfg_ecc_len | input | EW | ECC bytes per sector |
| cfg_even_req | input | 1 | Wide-bus or double-rate mode: lengths must be even |
| cfg_hole_en | input | 1 | Enable skipping of the bad-block-mark hole |
| cfg_hole_at | input | CW | First column of the hole |
| cfg_hole_len | input | CW | Hole length in columns |
| cfg_page_limit | input | CW | Physical page size in bytes |
| in_valid | input | 1 | Host byte valid |
| in_data | input | DW | Host byte |
| in_ready | output | 1 | Host byte accepted when valid |
| sum_req | output | 1 | Checksum byte wanted |
| sum_valid | input | 1 | Checksum byte available |
| sum_data | input | DW | Checksum byte |
| ecc_req | output | 1 | ECC byte wanted |
| ecc_valid | input | 1 | ECC byte available |
| ecc_data | input | DW | ECC byte |
| out_valid | output | 1 | Device byte valid |
| out_data | output | DW | Device byte |
| out_ready | input | 1 | Device side accepts |
| busy | output | 1 | Page in progress |
| done | output | 1 | One-cycle end-of-page pulse |
| cfg_err | output | 1 | Last start rejected for illegal sizes |
| ovf_err | output | 1 | Last start rejected for page overflow |
| sect_stb | output | 1 | First byte of a sector is being accepted |
| sect_col | output | CW | Device column of the current byte |

## Verification
The hard cases are cycles where the hole jump lands together with another event. One test places the hole exactly where a sector's first byte would go, so the jump and the sector-start report happen back to back. Another test places the hole in the middle of an ECC trailer while the source valids and `out_ready` toggle pseudo-randomly. A behavioural model in the bench builds the expected byte list and the expected sector start columns from the configuration alone. It compares each accepted byte, each side handshake, `sect_col`, `busy` and `done` on every clock. A jump placed wrongly shows up as a shifted sector column, and a byte consumed for the hole shows up as a data mismatch.

// File: rtl/nsf_pkg.sv
package nsf_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_DATA,
        S_SUM,
        S_ECC,
        S_PAD
    } phase_t;

    localparam int SUM_BYTES = 8;
endpackage

// File: rtl/nsf_cfg_check.sv
module nsf_cfg_check
    import nsf_pkg::*;
#(
    parameter int CW  = 12,
    parameter int SCW = 6,
    parameter int EW  = 8
) (
    input  logic [SCW-1:0] sectors,
    input  logic [CW-1:0]  body_len,
    input  logic [CW-1:0]  tail_len,
    input  logic           sum_en,
    input  logic [EW-1:0]  ecc_len,
    input  logic           even_req,
    input  logic           hole_en,
    input  logic [CW-1:0]  hole_len,
    input  logic [CW-1:0]  page_limit,
    output logic           bad,
    output logic           over
);
    localparam int FW = CW + 2;
    localparam int TW = FW + SCW + 1;

    logic [FW-1:0] trail, foot_b, foot_t;
    logic [TW-1:0] total;

    function automatic logic [FW-1:0] round8(input logic [FW-1:0] v);
        return (v + FW'(7)) & ~FW'(7);
    endfunction

    always_comb begin
        trail  = (sum_en ? FW'(SUM_BYTES) : FW'(0)) + FW'(ecc_len);
        foot_b = round8(FW'(body_len) + trail);
        foot_t = round8(FW'(tail_len) + trail);
        total  = TW'(sectors - SCW'(1)) * TW'(foot_b) + TW'(foot_t)
               + (hole_en ? TW'(hole_len) : TW'(0));
        bad    = (sectors == '0) || (body_len == '0) || (tail_len == '0)
               || (even_req && (body_len[0] || tail_len[0]));
        over   = total > TW'(page_limit);
    end
endmodule

// File: rtl/nsf_column.sv
module nsf_column #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          active,
    input  logic          adv,
    input  logic          hole_en,
    input  logic [CW-1:0] hole_at,
    input  logic [CW-1:0] hole_len,
    output logic [CW-1:0] col,
    output logic          hit
);
    logic [CW-1:0] col_q;
    logic [CW:0]   hole_end;

    assign col      = col_q;
    assign hit      = active && hole_en && (hole_len != '0) && (col_q == hole_at);
    assign hole_end = {1'b0, hole_at} + {1'b0, hole_len};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       col_q <= '0;
        else if (clear)   col_q <= '0;
        else if (hit)     col_q <= hole_at + hole_len;
        else if (adv)     col_q <= col_q + CW'(1);
    end

    // R6: an accepted byte never sits inside the reserved hole
    p_no_emit_in_hole_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && hole_en && hole_len != '0) |->
        ({1'b0, col_q} < {1'b0, hole_at} || {1'b0, col_q} >= hole_end));
endmodule

// File: rtl/nsf_framer.sv
module nsf_framer
    import nsf_pkg::*;
#(
    parameter int CW  = 12,
    parameter int SCW = 6,
    parameter int EW  = 8,
    parameter int DW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [SCW-1:0] cfg_sectors,
    input  logic [CW-1:0]  cfg_body_len,
    input  logic [CW-1:0]  cfg_tail_len,
    input  logic           cfg_sum_en,
    input  logic [EW-1:0]  cfg_ecc_len,
    input  logic           cfg_even_req,
    input  logic           cfg_hole_en,
    input  logic [CW-1:0]  cfg_hole_at,
    input  logic [CW-1:0]  cfg_hole_len,
    input  logic [CW-1:0]  cfg_page_limit,
    input  logic           in_valid,
    input  logic [DW-1:0]  in_data,
    output logic           in_ready,
    output logic           sum_req,
    input  logic           sum_valid,
    input  logic [DW-1:0]  sum_data,
    output logic           ecc_req,
    input  logic           ecc_valid,
    input  logic [DW-1:0]  ecc_data,
    output logic           out_valid,
    output logic [DW-1:0]  out_data,
    input  logic           out_ready,
    output logic           busy,
    output logic           done,
    output logic           cfg_err,
    output logic           ovf_err,
    output logic           sect_stb,
    output logic [CW-1:0]  sect_col
);
    phase_t         state_q, state_d, after;
    logic [SCW-1:0] sidx_q;
    logic [CW-1:0]  ph_cnt_q, d_len, col;
    logic [2:0]     mod_q, mod_nx;
    logic           done_q, cfg_err_q, ovf_err_q;
    logic           cfg_bad, ovf_bad, hole_hit, idle, start_ok;
    logic           fire, ph_end, sec_end, last_sec, src_valid;
    logic [DW-1:0]  src_data;

    assign idle     = (state_q == S_IDLE);
    assign start_ok = idle && start && !cfg_bad && !ovf_bad;

    nsf_cfg_check #(.CW(CW), .SCW(SCW), .EW(EW)) u_chk (
        .sectors    (cfg_sectors),
        .body_len   (cfg_body_len),
        .tail_len   (cfg_tail_len),
        .sum_en     (cfg_sum_en),
        .ecc_len    (cfg_ecc_len),
        .even_req   (cfg_even_req),
        .hole_en    (cfg_hole_en),
        .hole_len   (cfg_hole_len),
        .page_limit (cfg_page_limit),
        .bad        (cfg_bad),
        .over       (ovf_bad)
    );

    nsf_column #(.CW(CW)) u_col (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start_ok),
        .active   (!idle),
        .adv      (fire),
        .hole_en  (cfg_hole_en),
        .hole_at  (cfg_hole_at),
        .hole_len (cfg_hole_len),
        .col      (col),
        .hit      (hole_hit)
    );

    // output process: source selection and handshakes
    always_comb begin
        last_sec  = (sidx_q == cfg_sectors - SCW'(1));
        d_len     = last_sec ? cfg_tail_len : cfg_body_len;
        src_valid = 1'b0;
        src_data  = '0;
        unique case (state_q)
            S_IDLE: ;
            S_DATA: begin src_valid = in_valid;  src_data = in_data;  end
            S_SUM:  begin src_valid = sum_valid; src_data = sum_data; end
            S_ECC:  begin src_valid = ecc_valid; src_data = ecc_data; end
            S_PAD:  src_valid = 1'b1;
        endcase
        out_valid = !idle && !hole_hit && src_valid;
        out_data  = src_data;
        fire      = out_valid && out_ready;
        in_ready  = (state_q == S_DATA) && !hole_hit && out_ready;
        sum_req   = (state_q == S_SUM)  && !hole_hit && out_ready;
        ecc_req   = (state_q == S_ECC)  && !hole_hit && out_ready;
        sect_stb  = fire && (state_q == S_DATA) && (ph_cnt_q == '0);
        sect_col  = col;
        busy      = !idle;
        done      = done_q;
        cfg_err   = cfg_err_q;
        ovf_err   = ovf_err_q;
    end

    // next-state process
    always_comb begin
        mod_nx = mod_q + 3'd1;
        ph_end = 1'b0;
        after  = S_IDLE;
        unique case (state_q)
            S_IDLE: ;
            S_DATA: begin
                ph_end = fire && (ph_cnt_q == d_len - CW'(1));
                after  = cfg_sum_en ? S_SUM :
                         (cfg_ecc_len != '0) ? S_ECC :
                         (mod_nx != 3'd0) ? S_PAD : S_IDLE;
            end
            S_SUM: begin
                ph_end = fire && (ph_cnt_q == CW'(SUM_BYTES - 1));
                after  = (cfg_ecc_len != '0) ? S_ECC :
                         (mod_nx != 3'd0) ? S_PAD : S_IDLE;
            end
            S_ECC: begin
                ph_end = fire && (ph_cnt_q == CW'(cfg_ecc_len) - CW'(1));
                after  = (mod_nx != 3'd0) ? S_PAD : S_IDLE;
            end
            S_PAD: begin
                ph_end = fire && (mod_q == 3'd7);
                after  = S_IDLE;
            end
        endcase
        sec_end = ph_end && (after == S_IDLE);
        state_d = state_q;
        if (idle) begin
            if (start_ok) state_d = S_DATA;
        end else if (ph_end) begin
            state_d = (after != S_IDLE) ? after : (last_sec ? S_IDLE : S_DATA);
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // counters and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sidx_q    <= '0;
            ph_cnt_q  <= '0;
            mod_q     <= '0;
            done_q    <= 1'b0;
            cfg_err_q <= 1'b0;
            ovf_err_q <= 1'b0;
        end else begin
            done_q <= sec_end && last_sec;
            if (idle && start) begin
                cfg_err_q <= cfg_bad;
                ovf_err_q <= !cfg_bad && ovf_bad;
            end
            if (start_ok) begin
                sidx_q   <= '0;
                ph_cnt_q <= '0;
                mod_q    <= '0;
            end else if (fire) begin
                mod_q    <= mod_nx;
                ph_cnt_q <= ph_end ? '0 : ph_cnt_q + CW'(1);
                if (sec_end && !last_sec) sidx_q <= sidx_q + SCW'(1);
            end
        end
    end

    // R4: each sector starts on an 8-byte footprint boundary
    p_sector_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sect_stb |-> (mod_q == 3'd0));

    // R10: a stalled padding byte is still offered, still zero, next cycle
    p_pad_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PAD && out_valid && !out_ready) |=>
        (state_q == S_PAD && out_valid && out_data == '0));

    // R9: done is a single pulse while idle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy ##1 !done));

    // R5: illegal sizes block the page
    p_cfg_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start && cfg_bad) |=> (!busy && cfg_err));

    // R8: an oversize page is refused and nothing is emitted
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start && !cfg_bad && ovf_bad) |=> (!busy && ovf_err && !out_valid));
endmodule

// File: tb/nsf_framer_test.sv
module nsf_framer_test;
    localparam int CW = 12, SCW = 6, EW = 8, DW = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic           rst_n, start;
    logic [SCW-1:0] cfg_sectors;
    logic [CW-1:0]  cfg_body_len, cfg_tail_len, cfg_hole_at, cfg_hole_len, cfg_page_limit;
    logic           cfg_sum_en, cfg_even_req, cfg_hole_en;
    logic [EW-1:0]  cfg_ecc_len;
    logic           in_valid, in_ready, sum_req, sum_valid, ecc_req, ecc_valid;
    logic [DW-1:0]  in_data, sum_data, ecc_data, out_data;
    logic           out_valid, out_ready, busy, done, cfg_err, ovf_err, sect_stb;
    logic [CW-1:0]  sect_col;

    nsf_framer uut (.*);

    int vectors = 0, miscompares = 0;
    logic [7:0] exp_q[$];
    int kind_q[$];
    bit first_q[$];
    int scol_q[$];
    bit exp_busy = 0, exp_done = 0, exp_cfg = 0, exp_ovf = 0, drive_on = 0;
    int in_k = 0, sum_j = 0, ecc_j = 0, mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    int b_cnt, b_ss, b_ls, b_ecc, b_hat, b_hlen, b_phys;
    bit b_sum, b_even, b_hen;

    function automatic logic [7:0] in_val(int k);  return 8'((k * 7 + 3) & 255); endfunction
    function automatic logic [7:0] sum_val(int j); return 8'((160 + j) & 255); endfunction
    function automatic logic [7:0] ecc_val(int j); return 8'((j * 13 + 5) & 255); endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int pad8(int v); return (v + 7) / 8 * 8; endfunction

    function automatic bit cfg_illegal();
        return b_cnt == 0 || b_ss == 0 || b_ls == 0 || (b_even && ((b_ss % 2) || (b_ls % 2)));
    endfunction

    function automatic int page_total();
        int t, tr;
        tr = (b_sum ? 8 : 0) + b_ecc;
        t  = 0;
        for (int s = 0; s < b_cnt; s++) t += pad8(((s == b_cnt - 1) ? b_ls : b_ss) + tr);
        if (b_hen) t += b_hlen;
        return t;
    endfunction

    int mcol;
    task automatic put(input logic [7:0] v, input int kind, input bit first);
        if (b_hen && b_hlen > 0 && mcol == b_hat) mcol += b_hlen;
        exp_q.push_back(v); kind_q.push_back(kind); first_q.push_back(first);
        if (first) scol_q.push_back(mcol);
        mcol++;
    endtask

    task automatic build_page();
        int k, j, e, fp, len;
        k = 0; j = 0; e = 0; mcol = 0;
        for (int s = 0; s < b_cnt; s++) begin
            len = (s == b_cnt - 1) ? b_ls : b_ss;
            fp = 0;
            for (int i = 0; i < len; i++) begin put(in_val(k), 0, i == 0); k++; fp++; end
            if (b_sum) for (int i = 0; i < 8; i++) begin put(sum_val(j), 1, 0); j++; fp++; end
            for (int i = 0; i < b_ecc; i++) begin put(ecc_val(e), 2, 0); e++; fp++; end
            while (fp % 8 != 0) begin put(8'h00, 3, 0); fp++; end
        end
        in_k = 0; sum_j = 0; ecc_j = 0;
    endtask

    task automatic check_cycle();
        bit fire, old_busy, last;
        int hk;
        fire = out_valid && out_ready;
        hk = (exp_q.size() > 0) ? kind_q[0] : -1;
        old_busy = exp_busy;
        last = 0;
        chk(busy == exp_busy, "R9 busy", busy, exp_busy);
        chk(done == exp_done, "R9 done", done, exp_done);
        chk(cfg_err == exp_cfg, "R5 cfg_err", cfg_err, exp_cfg);
        chk(ovf_err == exp_ovf, "R8 ovf_err", ovf_err, exp_ovf);
        chk(!(out_valid && !exp_busy), "R8 no output while idle", out_valid, 0);
        chk(!in_ready || (exp_busy && hk == 0), "R11 in_ready outside data", in_ready, 0);
        chk((in_valid && in_ready) == (fire && hk == 0), "R1 input taken with data byte",
            in_valid && in_ready, fire && hk == 0);
        chk((sum_req && sum_valid) == (fire && hk == 1), "R2 checksum handshake",
            sum_req && sum_valid, fire && hk == 1);
        chk((ecc_req && ecc_valid) == (fire && hk == 2), "R3 ECC handshake",
            ecc_req && ecc_valid, fire && hk == 2);
        if (fire) begin
            if (exp_q.size() == 0) chk(0, "R10 extra byte", out_data, -1);
            else begin
                case (hk)
                    0: chk(out_data == exp_q[0], "R1 data byte", out_data, exp_q[0]);
                    1: chk(out_data == exp_q[0], "R2 checksum byte", out_data, exp_q[0]);
                    2: chk(out_data == exp_q[0], "R3 ECC byte", out_data, exp_q[0]);
                    default: chk(out_data == exp_q[0], "R4 pad byte", out_data, exp_q[0]);
                endcase
                chk(sect_stb == first_q[0], "R7 sector strobe", sect_stb, first_q[0]);
                if (first_q[0]) begin
                    chk(sect_col == CW'(scol_q[0]), "R7 sector column (R6 hole)", sect_col, scol_q[0]);
                    void'(scol_q.pop_front());
                end
                void'(exp_q.pop_front()); void'(kind_q.pop_front()); void'(first_q.pop_front());
                last = (exp_q.size() == 0);
            end
        end else chk(!sect_stb, "R7 stray strobe", sect_stb, 0);
        if (in_valid && in_ready) in_k++;
        if (sum_req && sum_valid) sum_j++;
        if (ecc_req && ecc_valid) ecc_j++;
        exp_done = last && old_busy;
        exp_busy = old_busy && !exp_done;
        if (start && !old_busy) begin
            exp_cfg = cfg_illegal();
            exp_ovf = !exp_cfg && (page_total() > b_phys);
            if (!exp_cfg && !exp_ovf) begin build_page(); exp_busy = 1; end
        end
    endtask

    always @(negedge clk) begin
        if (drive_on) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            in_valid  = (mode == 0) ? 1'b1 : lfsr[0];
            sum_valid = (mode == 0) ? 1'b1 : lfsr[3];
            ecc_valid = (mode == 0) ? 1'b1 : lfsr[5];
            out_ready = (mode == 0) ? 1'b1 : (lfsr[7] | lfsr[9]);
            in_data   = in_val(in_k);
            sum_data  = sum_val(sum_j);
            ecc_data  = ecc_val(ecc_j);
            #1;
            check_cycle();
        end
    end

    task automatic run_page(input int cnt, input int ss, input int ls, input bit sm, input int ecc,
                            input bit ev, input bit hen, input int hat, input int hlen,
                            input int phys, input int md, input bit restart, input string tag);
        int guard;
        @(posedge clk); #1;
        b_cnt = cnt; b_ss = ss; b_ls = ls; b_sum = sm; b_ecc = ecc; b_even = ev;
        b_hen = hen; b_hat = hat; b_hlen = hlen; b_phys = phys; mode = md;
        cfg_sectors = SCW'(cnt); cfg_body_len = CW'(ss); cfg_tail_len = CW'(ls);
        cfg_sum_en = sm; cfg_ecc_len = EW'(ecc); cfg_even_req = ev; cfg_hole_en = hen;
        cfg_hole_at = CW'(hat); cfg_hole_len = CW'(hlen); cfg_page_limit = CW'(phys);
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        if (restart) begin
            repeat (15) @(posedge clk);
            #1 start = 1'b1;
            @(posedge clk); #1 start = 1'b0;
        end
        guard = 0;
        while (exp_busy && guard < 20000) begin @(posedge clk); guard++; end
        repeat (3) @(posedge clk);
        chk(exp_q.size() == 0 && guard < 20000, {tag, " R10 every byte delivered"}, exp_q.size(), 0);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0;
        in_valid = 0; sum_valid = 0; ecc_valid = 0; out_ready = 0;
        in_data = '0; sum_data = '0; ecc_data = '0;
        cfg_sectors = '0; cfg_body_len = '0; cfg_tail_len = '0; cfg_sum_en = 0;
        cfg_ecc_len = '0; cfg_even_req = 0; cfg_hole_en = 0; cfg_hole_at = '0;
        cfg_hole_len = '0; cfg_page_limit = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk(busy == 0 && done == 0, "R9 reset idle", busy, 0);
        chk(out_valid == 0 && in_ready == 0, "R11 reset no traffic", out_valid, 0);
        chk(cfg_err == 0 && ovf_err == 0, "R5 reset flags clear", cfg_err, 0);
        rst_n = 1'b1;
        drive_on = 1'b1;
        // full rate, checksum and ECC, exact page fit, second start while busy (R12)
        run_page(3, 10, 14, 1, 7, 0, 0, 0, 0, 96, 0, 1, "T1 R12");
        // no trailers, hole inside a sector, random stalls
        run_page(2, 8, 5, 0, 0, 0, 1, 12, 6, 40, 1, 0, "T2");
        // hole exactly at the start column of sector 1
        run_page(3, 6, 6, 0, 2, 0, 1, 8, 4, 28, 1, 0, "T3");
        // odd length under even rule
        run_page(2, 9, 10, 0, 0, 1, 0, 0, 0, 200, 0, 0, "T4");
        chk(cfg_err == 1 && busy == 0, "R5 odd length rejected", cfg_err, 1);
        // zero sector count
        run_page(0, 8, 8, 0, 0, 0, 0, 0, 0, 200, 0, 0, "T5");
        chk(cfg_err == 1 && busy == 0, "R5 zero sectors rejected", cfg_err, 1);
        // one byte over the physical page
        run_page(3, 10, 14, 1, 7, 0, 0, 0, 0, 95, 0, 0, "T6");
        chk(ovf_err == 1 && cfg_err == 0 && busy == 0, "R8 overflow rejected", ovf_err, 1);
        // long ECC, hole inside the ECC trailer, stalls, even rule satisfied
        run_page(2, 4, 10, 1, 255, 1, 1, 100, 20, 1000, 1, 0, "T7");
        chk(ovf_err == 0 && cfg_err == 0, "R8 flags cleared by good start", ovf_err, 0);
        // checksum only, already aligned: no padding
        run_page(2, 16, 24, 1, 0, 0, 0, 0, 0, 56, 1, 0, "T8 R4");
        drive_on = 1'b0;
        #10;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(4 * 190000);
        miscompares++;
        $display("FAIL watchdog R9 run did not end actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule